// File: doc/BRIEF.md
# Branching Instruction Fetch Unit

This block owns the program counter of a single-cycle processor and supplies one 32-bit instruction word per clock. The word comes from a small internal word-addressed instruction array. The array is read combinationally at the current PC, so the instruction is valid in the same cycle that the PC holds its address.

On every rising edge the PC moves to one of two addresses. The first is the sequential address, PC + 4. The second is a PC-relative target: the incremented PC plus the low 16 bits of the current instruction, sign-extended and scaled by four. The target is taken only when the branch-request input and the externally supplied equality flag are both high. Decoding, register access and execution happen elsewhere.

The array is filled through a write port. While that port is enabled the PC holds its value, so code can be placed before fetching begins, or patched while fetching is paused.

Top module: `branch_fetch_unit`

## Requirements
- R1: While `rst_n` is low the PC reads 0, and it is cleared asynchronously. After `rst_n` rises, the PC stays at 0 through two more rising edges, and it first advances on the third.
- R2: `instr_o` always equals the array word at index `pc_o[IDX_W+1:2]`, where IDX_W = log2(IMEM_DEPTH). The two low PC bits and all PC bits above the index are ignored, so addresses wrap modulo the array size.
- R3: With `br_req` low and `ld_en` low, the next PC is PC + 4 whatever the value of `eq_flag`.
- R4: With `br_req` high and `eq_flag` low, the next PC is PC + 4.
- R5: With `br_req` and `eq_flag` both high, the next PC is PC + 4 + (sign-extended `instr_o[15:0]` shifted left by two).
- R6: A negative immediate branches backward. An immediate of 16'hFFFF keeps the PC on the branch instruction for as long as the branch stays taken.
- R7: While `ld_en` is high the PC holds its value. On each such rising edge, `ld_data` is written to array word `ld_addr`, and a write to the word at the current PC appears on `instr_o` after that edge.
- R8: The two low bits of the PC are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-stage synchronizer |
| br_req | input | 1 | Request to branch in this cycle |
| eq_flag | input | 1 | Equality flag from the execute stage; qualifies `br_req` |
| ld_en | input | 1 | Array write enable; also holds the PC |
| ld_addr | input | IDX_W | Word index for an array write |
| ld_data | input | 32 | Word to write into the array |
| pc_o | output | 32 | Current program counter (byte address) |
| instr_o | output | 32 | Instruction word fetched at `pc_o` |

## Verification
The bench gives `eq_flag` a high value while `br_req` is low. A select built from the flag alone would then jump instead of stepping by four. It drives branches with the immediates -1, -3 and -5. A design that zero-extends the immediate, or that adds the offset to the old PC instead of PC + 4, would land on the wrong word, and for -1 would fail to hold still. A large forward branch takes the PC past the end of the array, which exposes any index taken from the wrong PC bits. A mid-run reset checks the asynchronous clear and the two-edge release delay, and a write during a hold checks both that the PC freezes and that the new word reaches the output.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int PC_W    = 32;
  localparam int INSTR_W = 32;
  localparam int IMM_W   = 16;
  localparam int STEP    = 4;
  localparam int EXT_W   = PC_W - IMM_W - 2;
endpackage

// File: rtl/bfu_rst_sync.sv
module bfu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bfu_imem.sv
module bfu_imem #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/bfu_next_pc.sv
module bfu_next_pc
  import bfu_pkg::*;
(
  input  logic [PC_W-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  input  logic             br_req,
  input  logic             eq_flag,
  output logic [PC_W-1:0]  pc_nxt
);
  logic            take;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] offset;

  always_comb begin
    take   = br_req & eq_flag;
    seq_pc = pc + PC_W'(STEP);
    offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    pc_nxt = take ? (seq_pc + offset) : seq_pc;
  end
endmodule

// File: rtl/branch_fetch_unit.sv
module branch_fetch_unit
  import bfu_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  localparam int IDX_W = $clog2(IMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               br_req,
  input  logic               eq_flag,
  input  logic               ld_en,
  input  logic [IDX_W-1:0]   ld_addr,
  input  logic [INSTR_W-1:0] ld_data,
  output logic [PC_W-1:0]    pc_o,
  output logic [INSTR_W-1:0] instr_o
);
  logic            rst_sync_n;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  logic            pc_en;

  bfu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bfu_imem #(.DEPTH(IMEM_DEPTH), .WORD_W(INSTR_W)) u_mem (
    .clk   (clk),
    .we    (ld_en),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc_q[IDX_W+1:2]),
    .rdata (instr_o)
  );

  bfu_next_pc u_npc (
    .pc      (pc_q),
    .imm     (instr_o[IMM_W-1:0]),
    .br_req  (br_req),
    .eq_flag (eq_flag),
    .pc_nxt  (pc_nxt)
  );

  assign pc_en = ~ld_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pc_q <= '0;
    else if (pc_en)   pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker
  import bfu_pkg::*;
(
  input logic               clk,
  input logic               rst_ok_n,
  input logic               ld_en,
  input logic               br_req,
  input logic               eq_flag,
  input logic [PC_W-1:0]    pc,
  input logic [INSTR_W-1:0] instr
);
  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!ld_en && !br_req) |=> pc == $past(pc) + 32'd4);

  p_not_taken_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!ld_en && br_req && !eq_flag) |=> pc == $past(pc) + 32'd4);

  p_taken_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!ld_en && br_req && eq_flag) |=>
      pc == $past(pc) + 32'd4 + {{EXT_W{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  p_self_loop_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!ld_en && br_req && eq_flag && instr[15:0] == 16'hFFFF) |=> $stable(pc));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ld_en |=> $stable(pc));

  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    pc[1:0] == 2'b00);
endmodule

bind branch_fetch_unit bfu_checker u_chk (
  .clk      (clk),
  .rst_ok_n (rst_sync_n),
  .ld_en    (ld_en),
  .br_req   (br_req),
  .eq_flag  (eq_flag),
  .pc       (pc_o),
  .instr    (instr_o)
);

// File: tb/branch_fetch_unit_tb_top.sv
module branch_fetch_unit_tb_top;
  localparam int DEPTH = 64;
  localparam int IW    = $clog2(DEPTH);
  localparam int NVEC  = 10;

  // {br_req, eq_flag, expected next PC}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 32'd16},  // R5 forward +3 from 0
    {1'b1, 1'b0, 32'd20},  // R4 not taken
    {1'b0, 1'b1, 32'd24},  // R3 flag ignored
    {1'b1, 1'b1, 32'd8},   // R6 backward -5 from 24
    {1'b1, 1'b1, 32'd8},   // R6 -1 holds
    {1'b1, 1'b1, 32'd8},   // R6 -1 holds
    {1'b0, 1'b0, 32'd12},  // R3
    {1'b0, 1'b1, 32'd16},  // R3 flag ignored
    {1'b1, 1'b1, 32'd8},   // R6 backward -3 from 16
    {1'b0, 1'b0, 32'd12}   // R3
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            br_req, eq_flag, ld_en;
  logic [IW-1:0]   ld_addr;
  logic [31:0]     ld_data;
  logic [31:0]     pc_o, instr_o;
  logic [31:0]     img [DEPTH];
  int              n_chk = 0;
  int              n_fail = 0;
  bit              done = 1'b0;

  always #4 clk = ~clk;

  branch_fetch_unit #(.IMEM_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .br_req(br_req), .eq_flag(eq_flag),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pc_o(pc_o), .instr_o(instr_o)
  );

  function automatic logic [15:0] imm_of(int k);
    case (k)
      0:       return 16'h0003;
      2:       return 16'hFFFF;
      4:       return 16'hFFFD;
      6:       return 16'hFFFB;
      7:       return 16'h0040;
      default: return 16'h0100;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_fetch(input string req, input logic [31:0] exp_pc);
    check(pc_o == exp_pc, req, pc_o, exp_pc);
    check(instr_o == img[exp_pc[IW+1:2]], "R2", instr_o, img[exp_pc[IW+1:2]]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_pc;
    rst_n = 1'b0; br_req = 1'b0; eq_flag = 1'b0;
    ld_en = 1'b1; ld_addr = '0; ld_data = '0;
    for (int k = 0; k < DEPTH; k++) img[k] = {8'h3C, 8'(k), imm_of(k)};
    // fill the array through the write port
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      ld_addr = IW'(k); ld_data = img[k];
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_fetch("R1 reset value", 32'd0);
    ld_en = 1'b0;

    // vector walk
    exp_pc = 32'd0;
    for (int v = 0; v < NVEC; v++) begin
      br_req = VEC[v][33]; eq_flag = VEC[v][32];
      @(negedge clk);
      exp_pc = VEC[v][31:0];
      check_fetch("R3/R4/R5/R6 vector", exp_pc);
    end

    // sequential steps up to 28, with flag high (R3)
    br_req = 1'b0; eq_flag = 1'b1;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      exp_pc = exp_pc + 32'd4;
      check_fetch("R3 step", exp_pc);
    end

    // large forward branch past the array end: 28 + 4 + 256 = 288 -> word 8 (R2, R5)
    br_req = 1'b1; eq_flag = 1'b1;
    @(negedge clk);
    check_fetch("R5 wrap branch", 32'd288);
    check(pc_o[1:0] == 2'b00, "R8", pc_o, {pc_o[31:2], 2'b00});

    // hold and patch the current word (R7)
    ld_en = 1'b1; br_req = 1'b0; ld_addr = IW'(8); ld_data = 32'hDEAD_BEEF;
    @(negedge clk);
    img[8] = 32'hDEAD_BEEF;
    check_fetch("R7 hold", 32'd288);
    @(negedge clk);
    check_fetch("R7 hold", 32'd288);
    ld_en = 1'b0;
    @(negedge clk);
    check_fetch("R7 resume", 32'd292);

    // mid-run reset: async clear and two-edge release (R1)
    rst_n = 1'b0;
    #1;
    check(pc_o == 32'd0, "R1 async clear", pc_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc_o == 32'd0, "R1 release edge1", pc_o, 32'd0);
    @(negedge clk);
    check(pc_o == 32'd0, "R1 release edge2", pc_o, 32'd0);
    @(negedge clk);
    check_fetch("R1 first advance", 32'd4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule